// File: doc/BRIEF.md
# Burst-Coalescing Read Unit

This block takes single-word read requests and turns them into burst reads on a memory-mapped read master. Requests arrive one word address at a time over a valid/ready handshake. When a request's address is the next word after the words already gathered, it joins the open run. The run goes out as one burst read, starting at the run's first address, with a burst count equal to the number of words gathered. This happens when the run reaches the configured maximum length, when a request breaks the sequence, or when no new request has come for a configured number of cycles.

Each request is exactly one full data word of the memory port. The unit never packs narrower items into a word, and the burst count is always in words. The memory side can stall a command with waitrequest and returns data with variable latency, one word per readdatavalid beat. The unit forwards those beats to the requester in request order. Each beat carries a sequence tag: the tag is zero for the first request after reset and rises by one for each accepted request. A tracking FIFO holds the tag of every accepted request whose word has not yet returned. When that FIFO is full, the request input stalls.

Top module: `rd_burst_merger`

## Requirements
- R1: During and right after reset, mm_read and rsp_valid are 0 and req_ready is 1.
- R2: Requests whose addresses follow one another in steps of one (modulo 2^ADDR_W, so 0xFFFF is followed by 0x0000) are merged into one command. Its mm_address is the first address of the run and its mm_burstcount is the number of merged requests.
- R3: A run never holds more than MAX_BURST words. When the MAX_BURST-th word is accepted at a clock edge, mm_read is high after the next clock edge, with mm_burstcount equal to MAX_BURST.
- R4: A request whose address is not the run's first address plus its length, including an address below the run, causes the open run to be issued first. That request then starts a new run.
- R5: An open run that receives no request for IDLE_CYCLES consecutive clock edges after its last acceptance is issued on the following edge. mm_read is low after edge last+IDLE_CYCLES and high after edge last+IDLE_CYCLES+1.
- R6: While mm_read and mm_waitrequest are both high, mm_read, mm_address and mm_burstcount stay unchanged. The edge after waitrequest falls ends the command.
- R7: Whenever mm_read is high, mm_burstcount lies between 1 and MAX_BURST.
- R8: rsp_valid follows mm_readdatavalid in the same cycle. rsp_data is mm_readdata. rsp_tag is the request's sequence number modulo 2^TAG_W, and beats come back in request order.
- R9: When TRK_DEPTH requests are accepted but not yet answered, req_ready is 0. It returns to 1 once responses drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | Returned word present |
| rsp_data | output | DATA_W | Returned word |
| rsp_tag | output | TAG_W | Sequence tag of the returned word |
| mm_read | output | 1 | Burst read command valid |
| mm_address | output | ADDR_W | First word address of the burst |
| mm_burstcount | output | $clog2(MAX_BURST+1) | Words in the burst |
| mm_waitrequest | input | 1 | Memory not taking the command |
| mm_readdata | input | DATA_W | Read data beat |
| mm_readdatavalid | input | 1 | Read data beat valid |

## Verification
The response path is combinational, so rsp_valid, rsp_data and rsp_tag are compared in the same cycle the memory model raises readdatavalid. The model drives its inputs on the falling edge, and the checks read the outputs a moment later. A burst command shows up one edge after the cycle in which its issuing condition holds. The full-run and idle-timeout tests therefore sample mm_read half a cycle after the deciding edge, where it must still be low, and again one edge later, where it must be high. Ready is judged from the state the falling edge exposes, before the edge that would accept. The merged burst list for the vector table comes from a reference walk of the address rule in the bench.

// File: rtl/rbm_pkg.sv
// Shared types for the burst-coalescing read unit.
package rbm_pkg;
    // Reason the open run is being issued this cycle.
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_FULL  = 2'd1,
        CAUSE_BREAK = 2'd2,
        CAUSE_IDLE  = 2'd3
    } flush_cause_e;
endpackage

// File: rtl/rbm_run_gather.sv
// Gathers consecutive word requests into one run and decides when to issue it.
// Assumes: cmd_free means the command slot can take a new burst this cycle;
// trk_full means no further request may be tracked.
module rbm_run_gather
    import rbm_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int MAX_BURST   = 8,
    parameter int IDLE_CYCLES = 10,
    parameter int LEN_W       = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              trk_full,
    input  logic              cmd_free,
    output logic              req_ready,
    output logic              accept,
    output logic              launch,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [LEN_W-1:0]  launch_len
);
    localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);

    logic [ADDR_W-1:0] run_base;
    logic [LEN_W-1:0]  run_len;
    logic [IDLE_W-1:0] idle_cnt;
    logic              run_open;
    logic              run_full;
    logic              contig;
    logic              idle_hit;
    logic [ADDR_W-1:0] next_addr;
    flush_cause_e      cause;

    // Classify the incoming request against the open run.
    always_comb begin
        run_open  = (run_len != '0);
        run_full  = (run_len == LEN_W'(MAX_BURST));
        next_addr = run_base + ADDR_W'(run_len);
        contig    = run_open && (req_addr == next_addr);
        idle_hit  = run_open && (idle_cnt == IDLE_W'(IDLE_CYCLES));
    end

    // Pick the issue cause; a full run wins over a break, a break over idle.
    always_comb begin
        if (run_open && run_full)
            cause = CAUSE_FULL;
        else if (run_open && req_valid && !contig)
            cause = CAUSE_BREAK;
        else if (idle_hit)
            cause = CAUSE_IDLE;
        else
            cause = CAUSE_NONE;
    end

    // Issue and accept decisions.
    always_comb begin
        launch      = (cause != CAUSE_NONE) && cmd_free;
        launch_addr = run_base;
        launch_len  = run_len;
        req_ready   = !trk_full && (!run_open || launch || (contig && !run_full));
        accept      = req_valid && req_ready;
    end

    // Run base and length update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_base <= '0;
            run_len  <= '0;
        end else if (launch) begin
            if (accept) begin
                run_base <= req_addr;
                run_len  <= LEN_W'(1);
            end else begin
                run_len  <= '0;
            end
        end else if (accept) begin
            if (!run_open) begin
                run_base <= req_addr;
                run_len  <= LEN_W'(1);
            end else begin
                run_len  <= run_len + LEN_W'(1);
            end
        end
    end

    // Idle counter: cycles an open run has waited without a new request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_cnt <= '0;
        else if (accept || launch || !run_open)
            idle_cnt <= '0;
        else if (idle_cnt != IDLE_W'(IDLE_CYCLES))
            idle_cnt <= idle_cnt + IDLE_W'(1);
    end

    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= LEN_W'(MAX_BURST)); // R3
    AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_open && !accept && !launch) |=> ($stable(run_len) && $stable(run_base))); // R2
    AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (run_len <= LEN_W'(1))); // R4
endmodule

// File: rtl/rbm_cmd_port.sv
// Holds one burst read command toward memory until waitrequest releases it.
// Assumes launch is only raised when cmd_free is high.
module rbm_cmd_port #(
    parameter int ADDR_W    = 16,
    parameter int MAX_BURST = 8,
    parameter int BC_W      = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [BC_W-1:0]   launch_len,
    input  logic              mm_waitrequest,
    output logic              mm_read,
    output logic [ADDR_W-1:0] mm_address,
    output logic [BC_W-1:0]   mm_burstcount,
    output logic              cmd_free
);
    // Slot is free when empty or being taken at this edge.
    assign cmd_free = !mm_read || !mm_waitrequest;

    // Load a new command or retire the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mm_read       <= 1'b0;
            mm_address    <= '0;
            mm_burstcount <= '0;
        end else if (launch) begin
            mm_read       <= 1'b1;
            mm_address    <= launch_addr;
            mm_burstcount <= launch_len;
        end else if (!mm_waitrequest) begin
            mm_read       <= 1'b0;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_read && mm_waitrequest) |=> (mm_read && $stable(mm_address) && $stable(mm_burstcount))); // R6
    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mm_read |-> (mm_burstcount != '0 && mm_burstcount <= BC_W'(MAX_BURST))); // R7
endmodule

// File: rtl/rbm_tag_fifo.sv
// Synchronous FIFO of sequence tags for requests whose data is still due.
// Assumes DEPTH >= 2, no push when full and no pop when empty.
module rbm_tag_fifo #(
    parameter int TAG_W = 6,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [TAG_W-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign head_tag = store[rd_ptr];

    // Tag storage write.
    always_ff @(posedge clk) begin
        if (push)
            store[wr_ptr] <= push_tag;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8
endmodule

// File: rtl/rd_burst_merger.sv
// Burst-coalescing read unit: merges consecutive word reads into bursts and
// returns the data in request order with a sequence tag.
// Assumes the memory returns the beats of its bursts in command order.
module rd_burst_merger #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int MAX_BURST   = 8,
    parameter int IDLE_CYCLES = 10,
    parameter int TRK_DEPTH   = 16,
    parameter int TAG_W       = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [ADDR_W-1:0]              req_addr,
    output logic                           rsp_valid,
    output logic [DATA_W-1:0]              rsp_data,
    output logic [TAG_W-1:0]               rsp_tag,
    output logic                           mm_read,
    output logic [ADDR_W-1:0]              mm_address,
    output logic [$clog2(MAX_BURST+1)-1:0] mm_burstcount,
    input  logic                           mm_waitrequest,
    input  logic [DATA_W-1:0]              mm_readdata,
    input  logic                           mm_readdatavalid
);
    localparam int BC_W = $clog2(MAX_BURST + 1);

    logic              accept;
    logic              launch;
    logic [ADDR_W-1:0] launch_addr;
    logic [BC_W-1:0]   launch_len;
    logic              cmd_free;
    logic              trk_full;
    logic              trk_empty;
    logic [TAG_W-1:0]  seq_tag;
    logic [TAG_W-1:0]  head_tag;

    rbm_run_gather #(
        .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST),
        .IDLE_CYCLES(IDLE_CYCLES), .LEN_W(BC_W)
    ) gather_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .trk_full(trk_full), .cmd_free(cmd_free),
        .req_ready(req_ready), .accept(accept),
        .launch(launch), .launch_addr(launch_addr), .launch_len(launch_len)
    );

    rbm_cmd_port #(
        .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .BC_W(BC_W)
    ) cmd_i (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_addr(launch_addr), .launch_len(launch_len),
        .mm_waitrequest(mm_waitrequest),
        .mm_read(mm_read), .mm_address(mm_address),
        .mm_burstcount(mm_burstcount), .cmd_free(cmd_free)
    );

    rbm_tag_fifo #(
        .TAG_W(TAG_W), .DEPTH(TRK_DEPTH)
    ) trk_i (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .push_tag(seq_tag),
        .pop(mm_readdatavalid), .head_tag(head_tag),
        .full(trk_full), .empty(trk_empty)
    );

    // Sequence counter: tag handed to each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_tag <= '0;
        else if (accept)
            seq_tag <= seq_tag + TAG_W'(1);
    end

    // Return path: beats go straight back with the oldest outstanding tag.
    always_comb begin
        rsp_valid = mm_readdatavalid;
        rsp_data  = mm_readdata;
        rsp_tag   = head_tag;
    end

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        trk_full |-> !req_ready); // R9
    AST_BEAT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !trk_empty); // R8
endmodule

// File: tb/rd_burst_merger_tb_top.sv
// Self-checking bench: vector table of request runs, then directed tests.
module rd_burst_merger_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int ADDR_W = 16, DATA_W = 32, MAXB = 8, IDLE = 10, DEPTH = 16, TAG_W = 6;
    localparam int BC_W = $clog2(MAXB + 1);
    localparam int NV = 7;
    localparam logic [15:0] VA [NV] = '{16'h0100, 16'h0200, 16'h0300, 16'h02F0, 16'h0040, 16'h0045, 16'hFFFE};
    localparam int          VN [NV] = '{3, 8, 10, 1, 5, 2, 4};

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [TAG_W-1:0] rsp_tag;
    logic mm_read;
    logic [ADDR_W-1:0] mm_address;
    logic [BC_W-1:0] mm_burstcount;
    logic mm_waitrequest, mm_readdatavalid;
    logic [DATA_W-1:0] mm_readdata;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit force_wait = 0, hold_rsp = 0;
    logic [15:0] beat_addr [256];
    int beat_due [256];
    int bw = 0, br = 0, last_due = 0;
    logic [15:0] cmd_a [64];
    int cmd_n [64];
    int ncmd = 0;
    logic [15:0] exp_a [256];
    int ew = 0, er = 0;

    rd_burst_merger #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAXB),
        .IDLE_CYCLES(IDLE), .TRK_DEPTH(DEPTH), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_tag(rsp_tag), .mm_read(mm_read), .mm_address(mm_address),
        .mm_burstcount(mm_burstcount), .mm_waitrequest(mm_waitrequest),
        .mm_readdata(mm_readdata), .mm_readdatavalid(mm_readdatavalid));

    initial forever #2.5 clk = ~clk;

    function automatic logic [31:0] memf(input logic [15:0] a);
        return {a, ~a};
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic drop();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Memory model and monitors: drive on the falling edge, observe just after.
    initial begin
        mm_waitrequest = 1'b0;
        mm_readdatavalid = 1'b0;
        mm_readdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mm_waitrequest = force_wait;
            if (!hold_rsp && br != bw && beat_due[br % 256] <= cyc) begin
                mm_readdatavalid = 1'b1;
                mm_readdata = memf(beat_addr[br % 256]);
                br++;
            end else begin
                mm_readdatavalid = 1'b0;
            end
            #1;
            if (rst_n && mm_read && !mm_waitrequest) begin
                chk(mm_burstcount >= 1 && mm_burstcount <= MAXB, "R7 burstcount range", mm_burstcount, MAXB);
                if (ncmd < 64) begin
                    cmd_a[ncmd] = mm_address;
                    cmd_n[ncmd] = int'(mm_burstcount);
                end
                for (int i = 0; i < int'(mm_burstcount); i++) begin
                    int d;
                    d = cyc + 2 + (ncmd % 3) + i;
                    if (d <= last_due) d = last_due + 1;
                    last_due = d;
                    beat_addr[bw % 256] = mm_address + 16'(i);
                    beat_due[bw % 256] = d;
                    bw++;
                end
                ncmd++;
            end
            if (rst_n && rsp_valid) begin
                if (er >= ew) begin
                    chk(1'b0, "R8 beat without request", er, ew);
                end else begin
                    chk(rsp_data == memf(exp_a[er % 256]), "R8 data order", rsp_data, memf(exp_a[er % 256]));
                    chk(rsp_tag == TAG_W'(er), "R8 tag", rsp_tag, er % 64);
                    er++;
                end
            end
            #1;
            if (rst_n && req_valid && req_ready) begin
                exp_a[ew % 256] = req_addr;
                ew++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] eb_a [16];
        int eb_n [16];
        int ne, len, waitc;
        logic [15:0] base, a;
        ne = 0; len = 0; base = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(mm_read == 1'b0, "R1 mm_read in reset", mm_read, 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
        chk(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(mm_read == 1'b0 && req_ready == 1'b1, "R1 after reset", {mm_read, req_ready}, 1);

        // Reference walk of the merge rule for the vector table (R2, R3, R4).
        for (int g = 0; g < NV; g++) begin
            for (int k = 0; k < VN[g]; k++) begin
                a = VA[g] + 16'(k);
                if (len != 0 && a != base + 16'(len)) begin
                    eb_a[ne] = base; eb_n[ne] = len; ne++; len = 0;
                end
                if (len == 0) base = a;
                len++;
                if (len == MAXB) begin
                    eb_a[ne] = base; eb_n[ne] = len; ne++; len = 0;
                end
            end
        end
        if (len != 0) begin
            eb_a[ne] = base; eb_n[ne] = len; ne++;
        end

        for (int g = 0; g < NV; g++)
            for (int k = 0; k < VN[g]; k++)
                send(VA[g] + 16'(k));
        drop();
        repeat (60) @(posedge clk);
        chk(ncmd == ne, "R2 table burst count", ncmd, ne);
        for (int i = 0; i < ne; i++) begin
            chk(cmd_a[i] == eb_a[i], "R2/R4 table burst address", cmd_a[i], eb_a[i]);
            chk(cmd_n[i] == eb_n[i], "R2/R3 table burst length", cmd_n[i], eb_n[i]);
        end

        // R3: full run issues on the edge after the last word is accepted.
        for (int k = 0; k < MAXB; k++) send(16'h0500 + 16'(k));
        drop(); #1;
        chk(mm_read == 1'b0, "R3 not yet issued", mm_read, 0);
        @(negedge clk); #1;
        chk(mm_read == 1'b1 && mm_address == 16'h0500, "R3 full run issued", mm_address, 16'h0500);
        chk(mm_burstcount == MAXB, "R3 full burstcount", mm_burstcount, MAXB);
        repeat (30) @(posedge clk);

        // R5: idle timeout flush.
        send(16'h0600);
        send(16'h0601);
        drop();
        repeat (IDLE) @(posedge clk);
        @(negedge clk); #1;
        chk(mm_read == 1'b0, "R5 not issued before timeout", mm_read, 0);
        @(negedge clk); #1;
        chk(mm_read == 1'b1 && mm_address == 16'h0600, "R5 issued at timeout", mm_address, 16'h0600);
        chk(mm_burstcount == 2, "R5 partial burstcount", mm_burstcount, 2);
        repeat (30) @(posedge clk);

        // R6: command held under waitrequest.
        force_wait = 1;
        for (int k = 0; k < MAXB; k++) send(16'h0700 + 16'(k));
        drop();
        @(negedge clk); #1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(mm_read == 1'b1 && mm_address == 16'h0700 && mm_burstcount == MAXB,
                "R6 command held", {mm_read, mm_address}, {1'b1, 16'h0700});
        end
        force_wait = 0;
        @(negedge clk);
        @(negedge clk); #1;
        chk(mm_read == 1'b0, "R6 released after waitrequest falls", mm_read, 0);
        repeat (30) @(posedge clk);

        // R9: tracking full blocks requests until responses drain.
        hold_rsp = 1;
        for (int k = 0; k < DEPTH; k++) send(16'h0800 + 16'(k));
        @(negedge clk);
        req_addr = 16'h0810;
        #1;
        chk(req_ready == 1'b0, "R9 ready low when tracking full", req_ready, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            chk(req_ready == 1'b0, "R9 ready stays low", req_ready, 0);
        end
        hold_rsp = 0;
        waitc = 0;
        while (!req_ready && waitc < 60) begin
            @(negedge clk); #1;
            waitc++;
        end
        chk(req_ready == 1'b1, "R9 ready returns after drain", req_ready, 1);
        @(posedge clk);
        drop();
        repeat (80) @(posedge clk);
        chk(ew == 68, "R8 accepted request count", ew, 68);
        chk(er == ew, "R8 every request answered", er, ew);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule